// File: doc/BRIEF.md
# Modulus Counter Time Base

This block is a 24-bit modulus timer that can act as a general-purpose timer or as a shared time base for other timing channels. It advances either on a one-cycle prescaler tick from the surrounding logic or on edges of an external input pin. For the pin, the counting edge is programmable as rising only, falling only, or both edges. The counter climbs toward a programmable match value A.

Two count modes are available. In up mode the counter returns to zero at the match and raises a sticky flag. In up/down mode it turns around at A and again at zero, and the flag is raised at the zero turnaround. Software reads the count at any time, writes A through a one-word port, and clears the flag with a strobe.

Top module: `modulus_timebase`

## Requirements
- R1: After a clocked reset with `rst_n` low, the count is 0, the flag is 0, the match value is 0 and the direction is upward.
- R2: When `src_ext` is 0, the count changes only on clock edges where `tick_in` is 1. Each such edge makes exactly one step, and activity on `ext_pin` has no effect.
- R3: When `src_ext` is 1, `tick_in` is ignored. A qualifying change on `ext_pin` that is applied before a clock edge passes through two synchronizer stages. It moves the count on the third rising clock edge.
- R4: With `edge_both` = 0, `edge_rise` = 1 counts only 0-to-1 pin transitions, and `edge_rise` = 0 counts only 1-to-0 transitions.
- R5: With `edge_both` = 1, every pin transition counts once, whatever the value of `edge_rise`.
- R6: In up mode (`updown` = 0), a step taken while the count equals A loads 0 and sets the flag on the same edge. Any other step adds one.
- R7: In up mode, if A is rewritten below the current count, the counter keeps counting upward. It wraps from full scale to 0 without setting the flag, and matches A afterwards.
- R8: In up/down mode (`updown` = 1), a step at count A while counting up reverses the direction and moves the count to A-1. A step at count 0 while counting down reverses to upward, moves the count to 1 and sets the flag.
- R9: The flag stays set until `flag_clr` is pulsed. A clear in the same cycle as a new flag event leaves the flag set.
- R10: A write on `a_wr` takes effect on the next cycle. A step taken in the same cycle as the write compares against the old A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ext | input | 1 | 0: count prescaler ticks, 1: count pin edges |
| updown | input | 1 | 0: up mode, 1: up/down mode |
| edge_both | input | 1 | 1: count both pin edges |
| edge_rise | input | 1 | Single-edge polarity: 1 rising, 0 falling |
| tick_in | input | 1 | One-cycle prescaler tick |
| ext_pin | input | 1 | Asynchronous external count input |
| a_wr | input | 1 | Write strobe for the match value |
| a_wdata | input | 24 | Match value to write |
| flag_clr | input | 1 | Flag clear strobe |
| count | output | 24 | Current counter value |
| flag | output | 1 | Sticky match/turnaround flag |

## Verification
Two functions can fall in the same cycle: a flag event from a match or a turnaround, and the software clear. The bench provokes this in up mode with A = 1. It steps the counter until it sits at the match value, then pulses `flag_clr` together with the tick that causes the match. The flag must read 1 on the next sample, while a later clear on its own must drop it to 0. The vector table also writes A in the same cycle as a step, to show that the old value governs that step.

// File: rtl/mtb_pkg.sv
// Package: shared types for the modulus time base.
// Assumes: nothing beyond IEEE 1800-2017.
package mtb_pkg;
    // Count direction held by the counter core.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;

    // Pin edge qualification settings.
    typedef struct packed {
        logic both;
        logic rise;
    } edge_cfg_t;
endpackage

// File: rtl/mtb_edge_detect.sv
// Module: synchronizes the external pin and emits one-cycle pulses on the
// qualifying edges.
// Assumes: ext_pin is asynchronous; edge settings are quasi-static.
module mtb_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mtb_pkg::edge_cfg_t cfg,
    input  logic               pin,
    output logic               pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rose;
    logic                   fell;

    // Build the synchronizer chain, one flop per stage.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_next
                // Later stages shift the level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Qualify the detected transition by the edge settings.
    always_comb begin
        rose  = sync_q[LAST] & ~prev_q;
        fell  = ~sync_q[LAST] & prev_q;
        if (cfg.both)      pulse = rose | fell;
        else if (cfg.rise) pulse = rose;
        else               pulse = fell;
    end

    // A single-edge pulse must leave the level equal to the chosen polarity.
    assert_edge_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !cfg.both) |-> (sync_q[LAST] == cfg.rise));
endmodule

// File: rtl/mtb_counter.sv
// Module: modulus counter core with up and up/down modes.
// Assumes: adv is a one-cycle step request; a_val is the registered match value.
module mtb_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             updown,
    input  logic [CNT_W-1:0] a_val,
    output logic [CNT_W-1:0] count,
    output logic             evt
);
    import mtb_pkg::*;

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    dir_t             dir_q, dir_d;

    // Compute the next count, direction and flag event.
    always_comb begin
        cnt_d = cnt_q;
        dir_d = updown ? dir_q : DIR_UP;
        evt   = 1'b0;
        if (adv) begin
            if (!updown) begin
                if (cnt_q == a_val) begin
                    cnt_d = ZERO;
                    evt   = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (dir_q == DIR_UP) begin
                if (cnt_q == a_val) begin
                    if (a_val == ZERO) begin
                        evt = 1'b1;
                    end else begin
                        dir_d = DIR_DOWN;
                        cnt_d = cnt_q - ONE;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == ZERO) begin
                    dir_d = DIR_UP;
                    evt   = 1'b1;
                    cnt_d = (a_val == ZERO) ? ZERO : ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    // Register the count and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign count = cnt_q;

    // Without a step the count holds.
    assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q));

    // An up-mode step at the match returns to zero.
    assert_up_match_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !updown && cnt_q == a_val) |=> (cnt_q == ZERO));

    // A downward step at zero turns upward to one.
    assert_zero_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && updown && dir_q == DIR_DOWN && cnt_q == ZERO && a_val != ZERO)
        |=> (cnt_q == ONE && dir_q == DIR_UP));
endmodule

// File: rtl/mtb_flag.sv
// Module: sticky event flag with a software clear; a new event wins over
// a clear in the same cycle.
// Assumes: set and clr are synchronous one-cycle strobes.
module mtb_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // An event always leaves the flag set.
    assert_flag_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q);

    // A clear without an event drops the flag.
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q);
endmodule

// File: rtl/modulus_timebase.sv
// Module: top of the modulus time base. It selects the step source, holds
// the match register and joins the counter core with the sticky flag.
// Assumes: tick_in is a one-cycle prescaler strobe; ext_pin is asynchronous.
module modulus_timebase #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ext,
    input  logic             updown,
    input  logic             edge_both,
    input  logic             edge_rise,
    input  logic             tick_in,
    input  logic             ext_pin,
    input  logic             a_wr,
    input  logic [CNT_W-1:0] a_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    import mtb_pkg::*;

    logic [CNT_W-1:0] a_q;
    logic             ext_pulse;
    logic             adv;
    logic             evt;
    edge_cfg_t        ecfg;

    // Gather the edge settings into one struct.
    assign ecfg = '{both: edge_both, rise: edge_rise};

    // Load the match register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= '0;
        else if (a_wr) a_q <= a_wdata;
    end

    // Choose the step source.
    assign adv = src_ext ? ext_pulse : tick_in;

    mtb_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (ecfg),
        .pin   (ext_pin),
        .pulse (ext_pulse)
    );

    mtb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .updown (updown),
        .a_val  (a_q),
        .count  (count),
        .evt    (evt)
    );

    mtb_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt),
        .clr   (flag_clr),
        .flag  (flag)
    );

    // With the pin selected, an idle pin leaves the count unchanged.
    assert_ext_ignores_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && !ext_pulse) |=> $stable(count));
endmodule

// File: tb/modulus_timebase_test.sv
module modulus_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_ext = 1'b0, updown = 1'b0, edge_both = 1'b0, edge_rise = 1'b1;
    logic        tick_in = 1'b0, ext_pin = 1'b0, a_wr = 1'b0, flag_clr = 1'b0;
    logic [23:0] a_wdata = '0;
    logic [23:0] count;
    logic        flag;
    logic [7:0]  count_n;
    logic        flag_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    modulus_timebase uut (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .updown(updown),
        .edge_both(edge_both), .edge_rise(edge_rise), .tick_in(tick_in),
        .ext_pin(ext_pin), .a_wr(a_wr), .a_wdata(a_wdata), .flag_clr(flag_clr),
        .count(count), .flag(flag)
    );

    modulus_timebase #(.CNT_W(8)) uut_w8 (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .updown(updown),
        .edge_both(edge_both), .edge_rise(edge_rise), .tick_in(tick_in),
        .ext_pin(ext_pin), .a_wr(a_wr), .a_wdata(a_wdata[7:0]), .flag_clr(flag_clr),
        .count(count_n), .flag(flag_n)
    );

    typedef struct packed {
        logic        tick;
        logic        wr;
        logic [23:0] data;
        logic        clr;
        logic [23:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    // Internal-source, up-mode walk (R2, R6, R9, R10).
    localparam vec_t VEC [14] = '{
        '{1'b0, 1'b1, 24'd3, 1'b0, 24'd0, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd1, 1'b0},
        '{1'b0, 1'b0, 24'd0, 1'b0, 24'd1, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd2, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd3, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd0, 1'b1},
        '{1'b0, 1'b0, 24'd0, 1'b1, 24'd0, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd1, 1'b0},
        '{1'b1, 1'b1, 24'd5, 1'b0, 24'd2, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd3, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd4, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd5, 1'b0},
        '{1'b1, 1'b0, 24'd0, 1'b0, 24'd0, 1'b1},
        '{1'b1, 1'b0, 24'd0, 1'b1, 24'd1, 1'b0}
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_ext = 1'b0; updown = 1'b0; edge_both = 1'b0;
        edge_rise = 1'b1; tick_in = 1'b0; ext_pin = 1'b0; a_wr = 1'b0;
        flag_clr = 1'b0; a_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_a(input logic [23:0] v);
        a_wr = 1'b1; a_wdata = v;
        @(negedge clk);
        a_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    // Drive one pin level and check the three-edge latency (R3).
    task automatic pin_step(input logic lvl, input logic [23:0] inc, input string req);
        logic [23:0] c0;
        c0 = count;
        ext_pin = lvl;
        repeat (2) @(negedge clk);
        chk({req, " latency"}, count, c0);
        @(negedge clk);
        chk(req, count, c0 + inc);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 count", count, 24'd0);
        chk("R1 flag", {23'd0, flag}, 24'd0);

        // Vector table walk
        foreach (VEC[i]) begin
            tick_in = VEC[i].tick; a_wr = VEC[i].wr;
            a_wdata = VEC[i].data; flag_clr = VEC[i].clr;
            @(negedge clk);
            chk("R6/R9/R10 table count", count, VEC[i].exp_cnt);
            chk("R6/R9/R10 table flag", {23'd0, flag}, {23'd0, VEC[i].exp_flag});
            tick_in = 1'b0; a_wr = 1'b0; flag_clr = 1'b0;
        end

        // R2: pin activity ignored on the internal source
        for (int k = 0; k < 4; k++) begin
            ext_pin = ~ext_pin;
            repeat (3) @(negedge clk);
        end
        chk("R2 pin ignored", count, 24'd1);

        // R3/R4 rising edges, tick held high and ignored
        do_reset();
        write_a(24'd1000);
        src_ext = 1'b1; tick_in = 1'b1; edge_rise = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 tick ignored", count, 24'd0);
        pin_step(1'b1, 24'd1, "R4 rising counted");
        pin_step(1'b0, 24'd0, "R4 falling not counted");
        edge_rise = 1'b0;
        pin_step(1'b1, 24'd0, "R4 rising not counted");
        pin_step(1'b0, 24'd1, "R4 falling counted");
        edge_both = 1'b1;
        pin_step(1'b1, 24'd1, "R5 both rise");
        pin_step(1'b0, 24'd1, "R5 both fall");
        tick_in = 1'b0;

        // R7 wrap past full scale on the 8-bit instance
        do_reset();
        write_a(24'd200);
        ticks(20);
        chk("R7 pre", {16'd0, count_n}, 24'd20);
        write_a(24'd10);
        ticks(235);
        chk("R7 full scale", {16'd0, count_n}, 24'd255);
        ticks(1);
        chk("R7 wrap count", {16'd0, count_n}, 24'd0);
        chk("R7 wrap no flag", {23'd0, flag_n}, 24'd0);
        ticks(10);
        chk("R7 reach A", {16'd0, count_n}, 24'd10);
        ticks(1);
        chk("R7 match count", {16'd0, count_n}, 24'd0);
        chk("R7 match flag", {23'd0, flag_n}, 24'd1);

        // R8 up/down with A=3
        do_reset();
        write_a(24'd3);
        updown = 1'b1;
        begin
            int exp_seq [7] = '{1, 2, 3, 2, 1, 0, 1};
            for (int k = 0; k < 7; k++) begin
                ticks(1);
                chk("R8 updown count", count, exp_seq[k][23:0]);
                chk("R8 updown flag", {23'd0, flag}, (k == 6) ? 24'd1 : 24'd0);
            end
        end
        updown = 1'b0;

        // R9 clear colliding with a match
        do_reset();
        write_a(24'd1);
        ticks(2);
        chk("R9 first match", {23'd0, flag}, 24'd1);
        ticks(1);
        tick_in = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        tick_in = 1'b0; flag_clr = 1'b0;
        chk("R9 set beats clear flag", {23'd0, flag}, 24'd1);
        chk("R9 set beats clear count", count, 24'd0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R9 clear alone", {23'd0, flag}, 24'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule